// File: doc/BRIEF.md
# Two-Slot Delayed-Branch Fetch Sequencer

This block produces the instruction fetch address for a five-stage in-order pipeline whose stages are fetch, register read, execute, memory and writeback. Every cycle it drives a fetch address. In the same cycle it receives, for the word at that address, a branch flag, a call flag and a signed word offset. It keeps these in a two-entry shadow pipeline that follows the instruction through register read into execute. There, a taken input qualifies the transfer and any redirect is applied.

Every control transfer has two delay slots: the two words fetched after a branch always issue before its target. The target is the offset added to the address being fetched in the cycle the branch sits in execute. It is not added to the branch's own address. Branches and calls may sit in delay slots without restriction. Each redirect takes effect in order, one per cycle, so chains of branches can make the fetch address step downward. For calls, a link output gives the return address, which is the first word after both delay slots.

Top module: `pc_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `fetch_pc` is 0 and `link_vld` is 0.
- R2: With no taken branch reaching execute, `fetch_pc` increases by one each cycle.
- R3: A word fetched in cycle k with `ins_br`=1, taken in execute (`ex_taken`=1 in cycle k+2), makes `fetch_pc` in cycle k+3 equal to `fetch_pc` of cycle k+2 plus the sign-extended `ins_off`. A taken branch at 0 with offset 5 in straight-line code fetches 0, 1, 2, 7.
- R4: A branch with `ex_taken`=0 in its execute cycle has no effect, and fetch continues sequentially.
- R5: Branches inside delay slots redirect in order, one per cycle. Nops at 0 to 2 and taken branches of offset -1 at 3, 4 and 5 fetch 0,1,2,3,4,5,4,3,2,1,0,1,2,3,... from reset.
- R6: A taken call (`ins_br`=1, `ins_call`=1) asserts `link_vld` in its execute cycle, with `link_addr` equal to the call's own address plus 3.
- R7: All address arithmetic wraps modulo 2^PC_W. With PC_W=16, a taken branch at 0 with offset -3 fetches 0,1,2,0xFFFF,0,...
- R8: Reset clears the shadow pipeline, so a branch fetched before reset never redirects after it.
- R9: A call placed in a delay slot obeys the same two-slot rule, and its link value is still its own address plus 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_br | input | 1 | Fetched word is a control transfer |
| ins_call | input | 1 | Fetched transfer is a call (valid with ins_br) |
| ins_off | input | OFF_W | Signed word offset of the fetched transfer |
| ex_taken | input | 1 | Qualifies the transfer now in execute |
| fetch_pc | output | PC_W | Current fetch address |
| link_vld | output | 1 | A taken call is in execute |
| link_addr | output | PC_W | Return address of the call in execute |

## Verification
The sequencer is run on straight-line code, a single taken branch, and the same branch untaken. Together these separate sequential increment, the two-slot delay and the execute-time base address from a branch-relative one. A chain of three back-to-back branches drives the address backward and forward again, which exposes any ordering or base-address error in delay-slot redirects. A call at a plain position, a call in a branch's delay slot, a branch that wraps below zero, and a reset that arrives while a branch is in flight cover the link value, the delay-slot rule for calls, modular arithmetic and shadow clearing.

// File: rtl/pc_seq.sv
module pc_seq #(
  parameter int PC_W  = 16,
  parameter int OFF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_br,
  input  logic             ins_call,
  input  logic [OFF_W-1:0] ins_off,
  input  logic             ex_taken,
  output logic [PC_W-1:0]  fetch_pc,
  output logic             link_vld,
  output logic [PC_W-1:0]  link_addr
);

  localparam int EXT_W = PC_W - OFF_W;

  logic             rf_v, rf_br, rf_call;
  logic [OFF_W-1:0] rf_off;
  logic [PC_W-1:0]  rf_pc;

  logic             ex_v, ex_br, ex_call;
  logic [OFF_W-1:0] ex_off;
  logic [PC_W-1:0]  ex_pc;

  logic             redir;
  logic [PC_W-1:0]  target, next_pc;

  assign redir     = ex_v & ex_br & ex_taken;
  assign target    = fetch_pc + {{EXT_W{ex_off[OFF_W-1]}}, ex_off};
  assign next_pc   = redir ? target : fetch_pc + PC_W'(1);
  assign link_vld  = redir & ex_call;
  assign link_addr = ex_pc + PC_W'(3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_pc <= '0;
      rf_v     <= 1'b0;
      ex_v     <= 1'b0;
    end else begin
      fetch_pc <= next_pc;
      rf_v     <= 1'b1;
      ex_v     <= rf_v;
    end
  end

  always_ff @(posedge clk) begin
    rf_br   <= ins_br;
    rf_call <= ins_call;
    rf_off  <= ins_off;
    rf_pc   <= fetch_pc;
    ex_br   <= rf_br;
    ex_call <= rf_call;
    ex_off  <= rf_off;
    ex_pc   <= rf_pc;
  end

endmodule

// File: rtl/pc_seq_chk.sv
module pc_seq_chk #(
  parameter int PC_W  = 16,
  parameter int OFF_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ins_br,
  input logic             ins_call,
  input logic [OFF_W-1:0] ins_off,
  input logic             ex_taken,
  input logic [PC_W-1:0]  fetch_pc,
  input logic             link_vld,
  input logic [PC_W-1:0]  link_addr
);

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;

  function automatic logic [PC_W-1:0] sx(input logic [OFF_W-1:0] o);
    return PC_W'($signed(o));
  endfunction

  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd0) |-> (fetch_pc == '0 && !link_vld));

  a_r3_target: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(ins_br, 3) && $past(ex_taken))
      |-> fetch_pc == $past(fetch_pc) + sx($past(ins_off, 3)));

  a_r2_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && !($past(ins_br, 3) && $past(ex_taken)))
      |-> fetch_pc == $past(fetch_pc) + PC_W'(1));

  a_r6_link_addr: assert property (@(posedge clk) disable iff (!rst_n)
    link_vld |-> (link_addr == $past(fetch_pc, 2) + PC_W'(3) && $past(ins_call, 2)));

  a_r8_no_stale: assert property (@(posedge clk) disable iff (!rst_n)
    (age < 2'd2) |-> !link_vld);

endmodule

bind pc_seq pc_seq_chk #(.PC_W(PC_W), .OFF_W(OFF_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ins_br(ins_br), .ins_call(ins_call),
  .ins_off(ins_off), .ex_taken(ex_taken), .fetch_pc(fetch_pc),
  .link_vld(link_vld), .link_addr(link_addr)
);

// File: tb/pc_seq_tb_top.sv
module pc_seq_tb_top;
  localparam int PC_W  = 16;
  localparam int OFF_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [PC_W-1:0]  fetch_pc, link_addr;
  logic             ins_br, ins_call, ex_taken, link_vld;
  logic [OFF_W-1:0] ins_off;

  logic             p_br   [256];
  logic             p_call [256];
  logic [OFF_W-1:0] p_off  [256];

  assign ins_br   = p_br[fetch_pc[7:0]];
  assign ins_call = p_call[fetch_pc[7:0]];
  assign ins_off  = p_off[fetch_pc[7:0]];

  pc_seq #(.PC_W(PC_W), .OFF_W(OFF_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ins_br(ins_br), .ins_call(ins_call),
    .ins_off(ins_off), .ex_taken(ex_taken), .fetch_pc(fetch_pc),
    .link_vld(link_vld), .link_addr(link_addr)
  );

  typedef struct {
    logic [PC_W-1:0] pc;
    logic            lv;
    logic [PC_W-1:0] la;
    string           req;
  } item_t;

  item_t q[$];
  item_t cur;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input logic [PC_W-1:0] act, input logic [PC_W-1:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  always @(negedge clk)
    if (rst_n && q.size() > 0) begin
      cur = q.pop_front();
      chk(cur.req, "fetch_pc", fetch_pc, cur.pc);
      chk(cur.req, "link_vld", PC_W'(link_vld), PC_W'(cur.lv));
      if (cur.lv) chk(cur.req, "link_addr", link_addr, cur.la);
    end

  task automatic ex(input logic [PC_W-1:0] pc, input string req,
                    input logic lv = 1'b0, input logic [PC_W-1:0] la = '0);
    item_t it;
    it.pc = pc; it.lv = lv; it.la = la; it.req = req;
    q.push_back(it);
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) begin
      p_br[i] = 1'b0; p_call[i] = 1'b0; p_off[i] = '0;
    end
  endtask

  task automatic go();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", "fetch_pc in reset", fetch_pc, '0);
    chk("R1", "link_vld in reset", PC_W'(link_vld), '0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    while (q.size() != 0) @(negedge clk);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
      $finish;
    end
  end

  initial begin
    ex_taken = 1'b1;
    clear_prog();

    // R2 straight line
    for (int i = 0; i < 10; i++) ex(PC_W'(i), "R2");
    go();

    // R3 taken branch at 0, offset 5
    clear_prog(); p_br[0] = 1'b1; p_off[0] = 8'd5;
    ex(0, "R3"); ex(1, "R3"); ex(2, "R3"); ex(7, "R3"); ex(8, "R3"); ex(9, "R3");
    go();

    // R4 same branch untaken
    ex_taken = 1'b0;
    for (int i = 0; i < 7; i++) ex(PC_W'(i), "R4");
    go();
    ex_taken = 1'b1;

    // R5 chained branches in delay slots
    clear_prog();
    for (int i = 3; i <= 5; i++) begin p_br[i] = 1'b1; p_off[i] = 8'hFF; end
    begin
      int s [17] = '{0,1,2,3,4,5,4,3,2,1,0,1,2,3,4,5,4};
      foreach (s[i]) ex(PC_W'(s[i]), "R5");
    end
    go();

    // R6 call at 2, offset 10
    clear_prog(); p_br[2] = 1'b1; p_call[2] = 1'b1; p_off[2] = 8'd10;
    ex(0, "R6"); ex(1, "R6"); ex(2, "R6"); ex(3, "R6"); ex(4, "R6", 1'b1, 16'd5);
    ex(14, "R6"); ex(15, "R6");
    go();

    // R9 call in delay slot of branch at 0
    clear_prog(); p_br[0] = 1'b1; p_off[0] = 8'd5;
    p_br[1] = 1'b1; p_call[1] = 1'b1; p_off[1] = 8'd20;
    ex(0, "R9"); ex(1, "R9"); ex(2, "R9"); ex(7, "R9", 1'b1, 16'd4); ex(27, "R9"); ex(28, "R9");
    go();

    // R7 wrap below zero
    clear_prog(); p_br[0] = 1'b1; p_off[0] = 8'hFD;
    ex(0, "R7"); ex(1, "R7"); ex(2, "R7"); ex(16'hFFFF, "R7");
    ex(0, "R7"); ex(1, "R7"); ex(2, "R7"); ex(16'hFFFF, "R7"); ex(0, "R7");
    go();

    // R8 reset with a branch in flight
    clear_prog(); p_br[0] = 1'b1; p_off[0] = 8'd5;
    ex(0, "R8"); ex(1, "R8");
    go();
    clear_prog();
    for (int i = 0; i < 6; i++) ex(PC_W'(i), "R8");
    go();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule